// File: doc/BRIEF.md
# Dual-Path Instruction Dispatcher with Floating-Point Latency Emulation

This block sits between the register-read stage of a simple in-order pipeline and its write-back selector. Each instruction that arrives, already decoded and with its operands read, is steered by opcode class to one of two execution paths. Integer arithmetic, logic, jump, load and store opcodes go to the integer execute unit, which registers its result one clock after acceptance. The floating-point add and subtract opcodes go to a second execute unit. That unit has no memory data connection, and it computes plain integer addition or subtraction on the operands. To mimic the latency of a real floating-point pipeline, it is reached only through a chain of four delay registers.

The input follows valid/ready rules. An instruction is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` depends on combinational logic from the opcode and from the stall state of the target path only. Each path presents a result bundle (valid, destination, value, age tag) to the write-back selector, and a stall input from that selector. While a path's stall is high and its result is valid, that path holds the result unchanged. A stall on one path never blocks an instruction bound for the other path. Every accepted instruction gets the next value of a wrapping age counter, so the write-back stage can tell which of two simultaneous results is older.

Top module: `dual_path_dispatch`

## Requirements
- R1: After reset both result valids are low, `in_ready` is high, and the first accepted instruction carries age tag 0.
- R2: Opcodes 0 to 7 and 10 to 15 take the integer path. The result appears one clock after acceptance with value a+b (0), a-b (1), a&b (2), a|b (3), a^b (4), a+b for jump (5), load (6) and store (7), and 0 for 10 to 15. Values wrap modulo 2^DATA_W.
- R3: Opcodes 8 (add) and 9 (subtract) take the floating-point path and yield a+b or a-b respectively. With no stall, the result is valid exactly five clocks after acceptance: four delay registers plus the execute register.
- R4: An instruction never appears on the result valid of the path its opcode class does not select.
- R5: Each accepted instruction carries a tag one greater than the previous accepted one, modulo 2^TAG_W, whichever path it takes.
- R6: While `int_valid` and `int_stall` are both high, the integer result holds. An integer-class instruction is then refused (`in_ready` low).
- R7: While `fp_valid` and `fp_stall` are both high, the whole floating-point chain holds its contents and its result. A floating-point instruction is then refused. After the stall ends, the instructions in the chain resume in order without loss.
- R8: A stall on one path does not lower `in_ready` for an instruction of the other class, and such an instruction completes normally.
- R9: A cycle without acceptance moves a bubble into the paths. It produces no result and does not advance the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present from register-read stage |
| in_ready | output | 1 | Instruction accepted on this edge if in_valid |
| in_op | input | 4 | Opcode (encoding in R2/R3) |
| in_dst | input | REG_W | Destination register index |
| in_a | input | DATA_W | First operand |
| in_b | input | DATA_W | Second operand |
| int_stall | input | 1 | Write-back cannot take the integer result |
| int_valid | output | 1 | Integer result valid |
| int_dst | output | REG_W | Integer result destination |
| int_value | output | DATA_W | Integer result value |
| int_tag | output | TAG_W | Integer result age tag |
| fp_stall | input | 1 | Write-back cannot take the floating-point result |
| fp_valid | output | 1 | Floating-point result valid |
| fp_dst | output | REG_W | Floating-point result destination |
| fp_value | output | DATA_W | Floating-point result value |
| fp_tag | output | TAG_W | Floating-point result age tag |

## Verification
The hardest case to reach from the ports is a floating-point stall that lands while a second floating-point instruction is still inside the delay chain. The freeze must hold that instruction in place rather than lose it or let it advance. The stimulus issues two floating-point instructions back to back and raises the stall on the cycle the first result appears. During the stall it offers a floating-point instruction, which must be refused, and then an integer one, which must complete. It then checks that the second result emerges exactly one clock after the stall drops. Mixed streams with idle slots check routing, bubbles and the tag order, and the tag wraps during the run.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
  localparam int OP_W = 4;
  localparam logic [OP_W-1:0] OP_ADD   = 4'd0;
  localparam logic [OP_W-1:0] OP_SUB   = 4'd1;
  localparam logic [OP_W-1:0] OP_AND   = 4'd2;
  localparam logic [OP_W-1:0] OP_OR    = 4'd3;
  localparam logic [OP_W-1:0] OP_XOR   = 4'd4;
  localparam logic [OP_W-1:0] OP_JUMP  = 4'd5;
  localparam logic [OP_W-1:0] OP_LOAD  = 4'd6;
  localparam logic [OP_W-1:0] OP_STORE = 4'd7;
  localparam logic [OP_W-1:0] OP_FADD  = 4'd8;
  localparam logic [OP_W-1:0] OP_FSUB  = 4'd9;

  function automatic logic is_float_class(input logic [OP_W-1:0] op);
    return (op == OP_FADD) || (op == OP_FSUB);
  endfunction
endpackage

// File: rtl/dpd_dispatch.sv
module dpd_dispatch
  import dpd_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  in_op,
  input  logic             int_open,
  input  logic             fp_open,
  output logic             in_ready,
  output logic             send_int,
  output logic             send_fp,
  output logic [TAG_W-1:0] cur_tag
);
  logic float_op;
  logic accept;

  assign float_op = is_float_class(in_op);
  assign in_ready = float_op ? fp_open : int_open;
  assign accept   = in_valid && in_ready;
  assign send_int = accept && !float_op;
  assign send_fp  = accept && float_op;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_tag <= '0;
    end else if (accept) begin
      cur_tag <= cur_tag + 1'b1;
    end
  end
endmodule

// File: rtl/dpd_delay_chain.sv
module dpd_delay_chain #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data
);
  logic [DEPTH-1:0] stage_v;
  logic [WIDTH-1:0] stage_d [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic             src_v;
    logic [WIDTH-1:0] src_d;
    if (i == 0) begin : g_head
      assign src_v = in_valid;
      assign src_d = in_data;
    end else begin : g_body
      assign src_v = stage_v[i-1];
      assign src_d = stage_d[i-1];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        stage_v[i] <= 1'b0;
      end else if (advance) begin
        stage_v[i] <= src_v;
      end
    end

    always_ff @(posedge clk) begin
      if (advance) begin
        stage_d[i] <= src_d;
      end
    end
  end

  assign out_valid = stage_v[DEPTH-1];
  assign out_data  = stage_d[DEPTH-1];
endmodule

// File: rtl/dpd_exec_unit.sv
module dpd_exec_unit
  import dpd_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int REG_W      = 5,
  parameter int TAG_W      = 4,
  parameter bit FLOAT_ONLY = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   in_op,
  input  logic [REG_W-1:0]  in_dst,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              out_valid,
  output logic [REG_W-1:0]  out_dst,
  output logic [DATA_W-1:0] out_value,
  output logic [TAG_W-1:0]  out_tag
);
  logic [DATA_W-1:0] result;

  if (FLOAT_ONLY) begin : g_addsub
    // Stand-in for floating-point: integer add or subtract only
    always_comb begin
      if (in_op == OP_FSUB) result = in_a - in_b;
      else                  result = in_a + in_b;
    end
  end else begin : g_alu
    always_comb begin
      unique case (in_op)
        OP_ADD, OP_JUMP, OP_LOAD, OP_STORE, OP_FADD: result = in_a + in_b;
        OP_SUB, OP_FSUB: result = in_a - in_b;
        OP_AND:          result = in_a & in_b;
        OP_OR:           result = in_a | in_b;
        OP_XOR:          result = in_a ^ in_b;
        default:         result = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (advance) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (advance) begin
      out_dst   <= in_dst;
      out_value <= result;
      out_tag   <= in_tag;
    end
  end
endmodule

// File: rtl/dual_path_dispatch.sv
module dual_path_dispatch
  import dpd_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int REG_W    = 5,
  parameter int TAG_W    = 4,
  parameter int FP_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic [REG_W-1:0]  in_dst,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic              int_stall,
  output logic              int_valid,
  output logic [REG_W-1:0]  int_dst,
  output logic [DATA_W-1:0] int_value,
  output logic [TAG_W-1:0]  int_tag,
  input  logic              fp_stall,
  output logic              fp_valid,
  output logic [REG_W-1:0]  fp_dst,
  output logic [DATA_W-1:0] fp_value,
  output logic [TAG_W-1:0]  fp_tag
);
  localparam int BUNDLE_W = OP_W + REG_W + 2*DATA_W + TAG_W;

  logic             int_adv, fp_adv;
  logic             send_int, send_fp;
  logic [TAG_W-1:0] cur_tag;

  // A path moves forward unless its held result is refused downstream
  assign int_adv = !(int_valid && int_stall);
  assign fp_adv  = !(fp_valid && fp_stall);

  dpd_dispatch #(.TAG_W(TAG_W)) u_disp (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_op    (in_op),
    .int_open (int_adv),
    .fp_open  (fp_adv),
    .in_ready (in_ready),
    .send_int (send_int),
    .send_fp  (send_fp),
    .cur_tag  (cur_tag)
  );

  dpd_exec_unit #(
    .DATA_W(DATA_W), .REG_W(REG_W), .TAG_W(TAG_W), .FLOAT_ONLY(1'b0)
  ) u_int_exec (
    .clk       (clk),
    .rst       (rst),
    .advance   (int_adv),
    .in_valid  (send_int),
    .in_op     (in_op),
    .in_dst    (in_dst),
    .in_a      (in_a),
    .in_b      (in_b),
    .in_tag    (cur_tag),
    .out_valid (int_valid),
    .out_dst   (int_dst),
    .out_value (int_value),
    .out_tag   (int_tag)
  );

  logic [BUNDLE_W-1:0] chain_in, chain_out;
  logic                chain_v;
  logic [OP_W-1:0]     c_op;
  logic [REG_W-1:0]    c_dst;
  logic [DATA_W-1:0]   c_a, c_b;
  logic [TAG_W-1:0]    c_tag;

  assign chain_in = {in_op, in_dst, in_a, in_b, cur_tag};
  assign {c_op, c_dst, c_a, c_b, c_tag} = chain_out;

  dpd_delay_chain #(.DEPTH(FP_DEPTH), .WIDTH(BUNDLE_W)) u_chain (
    .clk       (clk),
    .rst       (rst),
    .advance   (fp_adv),
    .in_valid  (send_fp),
    .in_data   (chain_in),
    .out_valid (chain_v),
    .out_data  (chain_out)
  );

  dpd_exec_unit #(
    .DATA_W(DATA_W), .REG_W(REG_W), .TAG_W(TAG_W), .FLOAT_ONLY(1'b1)
  ) u_fp_exec (
    .clk       (clk),
    .rst       (rst),
    .advance   (fp_adv),
    .in_valid  (chain_v),
    .in_op     (c_op),
    .in_dst    (c_dst),
    .in_a      (c_a),
    .in_b      (c_b),
    .in_tag    (c_tag),
    .out_valid (fp_valid),
    .out_dst   (fp_dst),
    .out_value (fp_value),
    .out_tag   (fp_tag)
  );
endmodule

// File: rtl/dual_path_dispatch_checker.sv
module dual_path_dispatch_checker
  import dpd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int REG_W  = 5,
  parameter int TAG_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [3:0]        in_op,
  input logic              int_stall,
  input logic              int_valid,
  input logic [REG_W-1:0]  int_dst,
  input logic [DATA_W-1:0] int_value,
  input logic [TAG_W-1:0]  int_tag,
  input logic              fp_stall,
  input logic              fp_valid,
  input logic [REG_W-1:0]  fp_dst,
  input logic [DATA_W-1:0] fp_value,
  input logic [TAG_W-1:0]  fp_tag
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!int_valid && !fp_valid));

  p_int_issue_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !is_float_class(in_op)) |=> int_valid);

  p_int_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (int_valid && int_stall) |=> (int_valid && $stable(int_value)
                                  && $stable(int_tag) && $stable(int_dst)));

  p_int_refuse_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !is_float_class(in_op) && int_valid && int_stall) |-> !in_ready);

  p_fp_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (fp_valid && fp_stall) |=> (fp_valid && $stable(fp_value)
                                && $stable(fp_tag) && $stable(fp_dst)));

  p_fp_refuse_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_float_class(in_op) && fp_valid && fp_stall) |-> !in_ready);

  p_cross_open_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_float_class(in_op) && !(fp_valid && fp_stall)) |-> in_ready);
endmodule

bind dual_path_dispatch dual_path_dispatch_checker #(
  .DATA_W(DATA_W), .REG_W(REG_W), .TAG_W(TAG_W)
) u_checker (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
  .int_stall(int_stall), .int_valid(int_valid), .int_dst(int_dst),
  .int_value(int_value), .int_tag(int_tag),
  .fp_stall(fp_stall), .fp_valid(fp_valid), .fp_dst(fp_dst),
  .fp_value(fp_value), .fp_tag(fp_tag)
);

// File: tb/dual_path_dispatch_test.sv
`timescale 1ns/1ps
module dual_path_dispatch_test;
  localparam int DW = 16;
  localparam int RW = 5;
  localparam int TW = 4;
  localparam int NMAX = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [3:0]    in_op = '0;
  logic [RW-1:0] in_dst = '0;
  logic [DW-1:0] in_a = '0, in_b = '0;
  logic          int_stall = 1'b0, fp_stall = 1'b0;
  logic          int_valid, fp_valid;
  logic [RW-1:0] int_dst, fp_dst;
  logic [DW-1:0] int_value, fp_value;
  logic [TW-1:0] int_tag, fp_tag;

  always #10 clk = ~clk;

  dual_path_dispatch #(.DATA_W(DW), .REG_W(RW), .TAG_W(TW), .FP_DEPTH(4)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_dst(in_dst), .in_a(in_a), .in_b(in_b),
    .int_stall(int_stall), .int_valid(int_valid), .int_dst(int_dst),
    .int_value(int_value), .int_tag(int_tag),
    .fp_stall(fp_stall), .fp_valid(fp_valid), .fp_dst(fp_dst),
    .fp_value(fp_value), .fp_tag(fp_tag)
  );

  int checks = 0;
  int errors = 0;
  logic [TW-1:0] tag_ctr = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] model(input logic [3:0] op, input logic [DW-1:0] a,
                                          input logic [DW-1:0] b);
    case (op)
      4'd0, 4'd5, 4'd6, 4'd7, 4'd8: return a + b;
      4'd1, 4'd9: return a - b;
      4'd2: return a & b;
      4'd3: return a | b;
      4'd4: return a ^ b;
      default: return '0;
    endcase
  endfunction

  function automatic logic fp_class(input logic [3:0] op);
    return op == 4'd8 || op == 4'd9;
  endfunction

  logic          s_vld [NMAX];
  logic [3:0]    s_op  [NMAX];
  logic [DW-1:0] s_a   [NMAX];
  logic [DW-1:0] s_b   [NMAX];
  logic [RW-1:0] s_dst [NMAX];
  logic [TW-1:0] s_tag [NMAX];

  // Drives slots 0..n-1 one per cycle, no stalls, and scores both outputs
  task automatic run_stream(input int n, input string name);
    for (int c = 0; c < n + 6; c++) begin
      @(negedge clk);
      // integer path: slot c-1
      if (c >= 1 && c - 1 < n && s_vld[c-1] && !fp_class(s_op[c-1])) begin
        chk({name, " R2 int valid"}, {31'd0, int_valid}, 32'd1);
        chk({name, " R2 int value"}, {16'd0, int_value}, {16'd0, model(s_op[c-1], s_a[c-1], s_b[c-1])});
        chk({name, " R2 int dst"}, {27'd0, int_dst}, {27'd0, s_dst[c-1]});
        chk({name, " R5 int tag"}, {28'd0, int_tag}, {28'd0, s_tag[c-1]});
      end else if (c >= 1 && c - 1 < n && !s_vld[c-1]) begin
        chk({name, " R9 bubble int"}, {31'd0, int_valid}, 32'd0);
      end else begin
        chk({name, " R4 no int result"}, {31'd0, int_valid}, 32'd0);
      end
      // floating-point path: slot c-5
      if (c >= 5 && c - 5 < n && s_vld[c-5] && fp_class(s_op[c-5])) begin
        chk({name, " R3 fp valid"}, {31'd0, fp_valid}, 32'd1);
        chk({name, " R3 fp value"}, {16'd0, fp_value}, {16'd0, model(s_op[c-5], s_a[c-5], s_b[c-5])});
        chk({name, " R3 fp dst"}, {27'd0, fp_dst}, {27'd0, s_dst[c-5]});
        chk({name, " R5 fp tag"}, {28'd0, fp_tag}, {28'd0, s_tag[c-5]});
      end else begin
        chk({name, " R4 no fp result"}, {31'd0, fp_valid}, 32'd0);
      end
      if (c < n) begin
        in_valid = s_vld[c];
        in_op    = s_op[c];
        in_a     = s_a[c];
        in_b     = s_b[c];
        in_dst   = s_dst[c];
        s_tag[c] = tag_ctr;
        #1;
        if (s_vld[c]) begin
          chk({name, " R8 ready"}, {31'd0, in_ready}, 32'd1);
          tag_ctr = tag_ctr + 1'b1;
        end
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input logic [RW-1:0] d);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_dst = d;
  endtask

  bit done = 0;

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int n;
    logic [TW-1:0] tw, tx, tz, ta, tb;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 int_valid after reset", {31'd0, int_valid}, 32'd0);
    chk("R1 fp_valid after reset", {31'd0, fp_valid}, 32'd0);
    #1;
    chk("R1 in_ready after reset", {31'd0, in_ready}, 32'd1);

    // Integer sweep: every non-float opcode, two operand sets, idle slots
    n = 0;
    for (int pass = 0; pass < 2; pass++) begin
      for (int op = 0; op < 16; op++) begin
        if (op == 8 || op == 9) continue;
        s_vld[n] = 1'b1; s_op[n] = 4'(op);
        s_a[n] = (pass == 0) ? 16'(16'hF0F0 + op * 37) : 16'(op * 3);
        s_b[n] = (pass == 0) ? 16'(16'h0FF3 - op * 11) : 16'hFFFF;
        s_dst[n] = 5'(op + pass * 16);
        n++;
      end
      s_vld[n] = 1'b0; s_op[n] = 4'd0; s_a[n] = '0; s_b[n] = '0; s_dst[n] = '0; n++;
    end
    run_stream(n, "int sweep");   // first tag 0 checks R1, tag wraps (R5)

    // Float sweep: add/sub with carry and borrow edges, back to back and gapped
    n = 0;
    for (int k = 0; k < 12; k++) begin
      s_vld[n] = (k % 4 != 3); s_op[n] = (k % 2 == 0) ? 4'd8 : 4'd9;
      s_a[n] = (k < 4) ? 16'hFFFF : 16'(k * 1021);
      s_b[n] = (k < 4) ? 16'(k + 1) : 16'(16'h8000 + k);
      s_dst[n] = 5'(k + 3);
      n++;
    end
    run_stream(n, "fp sweep");

    // Mixed stream: interleaved classes, simultaneous results on both paths
    n = 0;
    for (int k = 0; k < 20; k++) begin
      s_vld[n] = (k != 7) && (k != 15);
      s_op[n] = (k % 3 == 0) ? 4'(k % 8) : ((k % 3 == 1) ? 4'd8 : 4'd9);
      s_a[n] = 16'(k * 4099 + 1);
      s_b[n] = 16'(k * 257 + 9);
      s_dst[n] = 5'(31 - k);
      n++;
    end
    run_stream(n, "mixed");

    // Float stall with a second float instruction inside the chain
    @(negedge clk);
    drive(4'd8, 16'd100, 16'd5, 5'd3); tw = tag_ctr; tag_ctr++;
    @(negedge clk);
    drive(4'd9, 16'd50, 16'd70, 5'd4); tx = tag_ctr; tag_ctr++;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 fp W valid", {31'd0, fp_valid}, 32'd1);
    chk("R3 fp W value", {16'd0, fp_value}, 32'd105);
    fp_stall = 1'b1;
    drive(4'd8, 16'd1, 16'd1, 5'd9);
    #1;
    chk("R7 float refused while stalled", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    chk("R7 fp held valid", {31'd0, fp_valid}, 32'd1);
    chk("R7 fp held value", {16'd0, fp_value}, 32'd105);
    chk("R7 fp held tag", {28'd0, fp_tag}, {28'd0, tw});
    drive(4'd4, 16'h00FF, 16'h0F0F, 5'd7); tz = tag_ctr;
    #1;
    chk("R8 int open during fp stall", {31'd0, in_ready}, 32'd1);
    tag_ctr++;
    @(negedge clk);
    chk("R8 int result during fp stall", {16'd0, int_value}, 32'h0FF0);
    chk("R8 int valid during fp stall", {31'd0, int_valid}, 32'd1);
    chk("R5 int tag during fp stall", {28'd0, int_tag}, {28'd0, tz});
    chk("R7 fp still held", {16'd0, fp_value}, 32'd105);
    in_valid = 1'b0;
    fp_stall = 1'b0;
    @(negedge clk);
    chk("R7 chained X resumes valid", {31'd0, fp_valid}, 32'd1);
    chk("R7 chained X value", {16'd0, fp_value}, {16'd0, 16'(16'd50 - 16'd70)});
    chk("R7 chained X tag", {28'd0, fp_tag}, {28'd0, tx});
    chk("R9 refused float made no int", {31'd0, int_valid}, 32'd0);
    @(negedge clk);
    chk("R7 refused float not in chain", {31'd0, fp_valid}, 32'd0);

    // Integer stall
    drive(4'd0, 16'd7, 16'd8, 5'd1); ta = tag_ctr; tag_ctr++;
    @(negedge clk);
    chk("R2 int A value", {16'd0, int_value}, 32'd15);
    int_stall = 1'b1;
    drive(4'd1, 16'd3, 16'd9, 5'd2);
    #1;
    chk("R6 int refused while stalled", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    chk("R6 int held value", {16'd0, int_value}, 32'd15);
    chk("R6 int held tag", {28'd0, int_tag}, {28'd0, ta});
    #1;
    chk("R6 still refused", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    int_stall = 1'b0;
    #1;
    chk("R6 ready after release", {31'd0, in_ready}, 32'd1);
    tb = tag_ctr; tag_ctr++;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6 int B value", {16'd0, int_value}, {16'd0, 16'(16'd3 - 16'd9)});
    chk("R5 int B tag", {28'd0, int_tag}, {28'd0, tb});
    chk("R4 int op not on fp", {31'd0, fp_valid}, 32'd0);
    @(negedge clk);
    chk("R9 idle after B", {31'd0, int_valid}, 32'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule